// File: doc/BRIEF.md
# Three-Operand Carry-Save Increment Adder

This block adds three unsigned operands of `WIDTH` bits in a single combinational pass and returns their exact total on `WIDTH+2` bits. It suits datapaths that must fold three values into one, such as accumulating a partial product with two addends, without first chaining two ordinary adders.

The work is done in two stages. In the first stage, each bit position has its own full adder. The third operand enters through the carry input of that full adder. The stage yields a sum vector and a carry vector, and no carry passes from one position to the next. In the second stage, the sum vector and the carry vector shifted one place up are added. For this addition the word is split into 4-bit slices. Every slice does its own ripple addition at the same moment, with a carry-in of zero. The lowest slice's bits go to the output unchanged. Each higher slice is then corrected by a chain of half adders, and that chain is driven by the carry leaving the slice below. Carry crosses a slice boundary only along these increment chains. The bit above the top slice is finished by one half adder that merges the top first-stage carry with the carry leaving the top slice.

Top module: `csa_inc_adder`

## Requirements
- R1: `total` equals the exact unsigned sum `opA + opB + opC` for every operand value, with no bit lost, on `WIDTH+2` bits.
- R2: With all three operands zero, `total` is zero.
- R3: With all three operands all ones, `total` equals 3·(2^WIDTH − 1), and its most significant bit is set (for WIDTH = 8 the value is 765).
- R4: A carry produced in a lower 4-bit slice reaches every higher slice. This includes a higher slice whose own partial sum is all ones, in which case the carry must travel through the whole increment chain (for example 0x0F + 0x01 + 0 = 0x010 and 0xFF + 0x01 + 0 = 0x100).
- R5: Bit 0 of `total` equals the exclusive OR of bit 0 of the three operands. The lowest slice's bits pass through the increment logic untouched.
- R6: The result does not depend on which port carries which operand. All six orderings of three given values give the same `total`.
- R7: A slice's own ripple carry-out and its increment-chain carry-out are never high together, so the carry leaving a slice is their OR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First unsigned operand |
| opB | input | WIDTH | Second unsigned operand |
| opC | input | WIDTH | Third unsigned operand, fed to the full-adder carry inputs |
| total | output | WIDTH+2 | Exact unsigned sum of the three operands |

## Verification
The immediate assertions assume that all operand bits are driven to 0 or 1 and hold still while the combinational logic settles. They compare values that the two stages produce separately, so an X or an input that changes mid-evaluation would make them meaningless. The bench only ever drives fully defined operands, which it changes on the falling clock edge and samples half a period later. Random operands come from `$urandom` and are masked to `WIDTH` bits, so every input pattern stays within the unsigned range the block accepts.

// File: rtl/csa_inc_pkg.sv
package csa_inc_pkg;
  localparam int SLICE_W = 4;

  typedef struct packed {
    logic [SLICE_W-1:0] bits;
    logic               carryOut;
  } sliceRes_t;
endpackage

// File: rtl/csa_row.sv
module csa_row #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] inA,
  input  logic [WIDTH-1:0] inB,
  input  logic [WIDTH-1:0] inC,
  output logic [WIDTH-1:0] sumVec,
  output logic [WIDTH-1:0] carryVec
);
  localparam int EXT_W = WIDTH + 2;

  for (genvar i = 0; i < WIDTH; i++) begin : g_fa
    assign sumVec[i]   = inA[i] ^ inB[i] ^ inC[i];
    assign carryVec[i] = (inA[i] & inB[i]) | (inC[i] & (inA[i] ^ inB[i]));
  end

  // The row must keep the weighted value of its three inputs (R1).
  always_comb begin
    a_r1_row_preserves_value: assert (
      EXT_W'(sumVec) + (EXT_W'(carryVec) << 1) ==
      EXT_W'(inA) + EXT_W'(inB) + EXT_W'(inC))
      else $error("carry-save row lost value");
  end
endmodule

// File: rtl/ripple_slice.sv
module ripple_slice
  import csa_inc_pkg::*;
(
  input  logic [SLICE_W-1:0] x,
  input  logic [SLICE_W-1:0] y,
  output sliceRes_t          res
);
  logic [SLICE_W:0] chain;

  assign chain[0] = 1'b0;
  for (genvar i = 0; i < SLICE_W; i++) begin : g_fa
    assign res.bits[i]  = x[i] ^ y[i] ^ chain[i];
    assign chain[i+1]   = (x[i] & y[i]) | (chain[i] & (x[i] ^ y[i]));
  end
  assign res.carryOut = chain[SLICE_W];
endmodule

// File: rtl/inc_chain.sv
module inc_chain
  import csa_inc_pkg::*;
(
  input  sliceRes_t          partial,
  input  logic               carryIn,
  output logic [SLICE_W-1:0] fixedBits,
  output logic               carryOut
);
  logic [SLICE_W:0] hc;

  assign hc[0] = carryIn;
  for (genvar i = 0; i < SLICE_W; i++) begin : g_ha
    assign fixedBits[i] = partial.bits[i] ^ hc[i];
    assign hc[i+1]      = partial.bits[i] & hc[i];
  end
  assign carryOut = partial.carryOut | hc[SLICE_W];

  // R7: a slice cannot overflow on its own and again through its increment.
  always_comb begin
    a_r7_carries_exclusive: assert (!(partial.carryOut && hc[SLICE_W]))
      else $error("slice and increment carries both set");
  end
endmodule

// File: rtl/inc_stage.sv
module inc_stage
  import csa_inc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] addX,
  input  logic [WIDTH-1:0] addY,
  output logic [WIDTH-1:0] result,
  output logic             carryOut
);
  localparam int SLICES = WIDTH / SLICE_W;

  sliceRes_t partial [SLICES];
  logic [SLICES-1:0] sliceCarry;

  for (genvar k = 0; k < SLICES; k++) begin : g_slice
    ripple_slice u_rip (
      .x  (addX[k*SLICE_W +: SLICE_W]),
      .y  (addY[k*SLICE_W +: SLICE_W]),
      .res(partial[k])
    );
    if (k == 0) begin : g_low
      assign result[SLICE_W-1:0] = partial[0].bits;
      assign sliceCarry[0]       = partial[0].carryOut;
    end else begin : g_up
      inc_chain u_inc (
        .partial  (partial[k]),
        .carryIn  (sliceCarry[k-1]),
        .fixedBits(result[k*SLICE_W +: SLICE_W]),
        .carryOut (sliceCarry[k])
      );
    end
  end
  assign carryOut = sliceCarry[SLICES-1];

  // R5: the lowest slice is the uncorrected ripple sum of its inputs.
  always_comb begin
    a_r5_low_slice_direct: assert (
      result[SLICE_W-1:0] == SLICE_W'(addX[SLICE_W-1:0] + addY[SLICE_W-1:0]))
      else $error("low slice was altered");
  end
endmodule

// File: rtl/csa_inc_adder.sv
module csa_inc_adder
  import csa_inc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  input  logic [WIDTH-1:0]   opC,
  output logic [WIDTH+1:0]   total
);
  localparam int OUT_W = WIDTH + 2;

  logic [WIDTH-1:0] sumVec;
  logic [WIDTH-1:0] carryVec;
  logic [WIDTH-1:0] shiftedCarry;
  logic [WIDTH-1:0] lowResult;
  logic             stageCarry;

  csa_row #(.WIDTH(WIDTH)) u_row (
    .inA     (opA),
    .inB     (opB),
    .inC     (opC),
    .sumVec  (sumVec),
    .carryVec(carryVec)
  );

  assign shiftedCarry = {carryVec[WIDTH-2:0], 1'b0};

  inc_stage #(.WIDTH(WIDTH)) u_stage (
    .addX    (sumVec),
    .addY    (shiftedCarry),
    .result  (lowResult),
    .carryOut(stageCarry)
  );

  assign total = {carryVec[WIDTH-1] & stageCarry,
                  carryVec[WIDTH-1] ^ stageCarry,
                  lowResult};

  always_comb begin
    a_r1_exact_total: assert (
      total == OUT_W'(opA) + OUT_W'(opB) + OUT_W'(opC))
      else $error("total differs from three-way sum");
    a_r5_lsb_parity: assert (total[0] == (opA[0] ^ opB[0] ^ opC[0]))
      else $error("bit 0 is not operand parity");
  end

  initial begin
    a_r1_width_multiple: assert (WIDTH % SLICE_W == 0 && WIDTH >= SLICE_W)
      else $error("WIDTH must be a multiple of the slice width");
  end
endmodule

// File: tb/csa_inc_adder_bench.sv
module csa_inc_adder_bench;
  localparam int WIDTH  = 8;
  localparam int OUT_W  = WIDTH + 2;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [WIDTH-1:0] opA = '0, opB = '0, opC = '0;
  logic [OUT_W-1:0] total;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  csa_inc_adder #(.WIDTH(WIDTH)) u_csa_inc_adder (
    .opA(opA), .opB(opB), .opC(opC), .total(total)
  );

  function automatic logic [OUT_W-1:0] refSum(logic [WIDTH-1:0] a, b, c);
    return OUT_W'(a) + OUT_W'(b) + OUT_W'(c);
  endfunction

  task automatic drive(input logic [WIDTH-1:0] a, b, c);
    @(negedge clk);
    opA = a; opB = b; opC = c;
    #(PERIOD/2);
  endtask

  task automatic expectVal(input string req, input logic [OUT_W-1:0] exp);
    checks++;
    if (total !== exp) begin
      errors++;
      $display("FAIL %s: total=%0d expected=%0d (a=%0h b=%0h c=%0h)",
               req, total, exp, opA, opB, opC);
    end
  endtask

  task automatic testZeros;
    drive('0, '0, '0);
    expectVal("R2", '0);
  endtask

  task automatic testOnes;
    logic [WIDTH-1:0] ones = '1;
    drive(ones, ones, ones);
    expectVal("R3", OUT_W'(3) * (OUT_W'(ones)));
    checks++;
    if (total[OUT_W-1] !== 1'b1) begin
      errors++;
      $display("FAIL R3: msb=%0b expected=1", total[OUT_W-1]);
    end
  endtask

  task automatic testBoundary;
    drive(8'h0F, 8'h01, 8'h00); expectVal("R4", 10'h010);
    drive(8'hFF, 8'h01, 8'h00); expectVal("R4", 10'h100);
    drive(8'h0F, 8'h0F, 8'h0F); expectVal("R4", 10'h02D);
    drive(8'hF8, 8'h04, 8'h04); expectVal("R4 R7", 10'h100);
    drive(8'hFF, 8'hFF, 8'h02); expectVal("R4 R7", 10'h200);
  endtask

  task automatic testLsb;
    for (int i = 0; i < 8; i++) begin
      logic [WIDTH-1:0] a = WIDTH'($urandom) & ~WIDTH'(1) | WIDTH'(i & 1);
      logic [WIDTH-1:0] b = WIDTH'($urandom) & ~WIDTH'(1) | WIDTH'((i >> 1) & 1);
      logic [WIDTH-1:0] c = WIDTH'($urandom) & ~WIDTH'(1) | WIDTH'((i >> 2) & 1);
      drive(a, b, c);
      checks++;
      if (total[0] !== (a[0] ^ b[0] ^ c[0])) begin
        errors++;
        $display("FAIL R5: bit0=%0b expected=%0b", total[0], a[0] ^ b[0] ^ c[0]);
      end
    end
  endtask

  task automatic testSymmetry;
    logic [WIDTH-1:0] v [3];
    v[0] = 8'hA7; v[1] = 8'h5C; v[2] = 8'h39;
    for (int p = 0; p < 3; p++) begin
      for (int q = 0; q < 3; q++) begin
        if (p != q) begin
          drive(v[p], v[q], v[3 - p - q]);
          expectVal("R6", refSum(v[0], v[1], v[2]));
        end
      end
    end
  endtask

  task automatic testRandom;
    for (int i = 0; i < 300; i++) begin
      logic [WIDTH-1:0] a = WIDTH'($urandom);
      logic [WIDTH-1:0] b = WIDTH'($urandom);
      logic [WIDTH-1:0] c = WIDTH'($urandom);
      drive(a, b, c);
      expectVal("R1", refSum(a, b, c));
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    testZeros();
    testOnes();
    testBoundary();
    testLsb();
    testSymmetry();
    testRandom();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule